// File: doc/BRIEF.md
# Register-Target Branch Resolver

This block settles control flow for the two branch opcodes of a 32-bit load-store processor with 32 general registers. The fetch stage has already advanced the program counter by 4. That incremented PC arrives here together with the instruction word. The block names two source registers, taken from the rb and rc fields, to the register file through plain read-index outputs. It receives their contents back on the same cycle.

The jump target is always the full contents of the rb register; no offset is ever added. A 3-bit test code in the low bits of the instruction decides whether the jump happens. The test looks only at the rc register. The link form of the branch always writes the incremented PC into the ra register, whether the jump is taken or not. With the "never" test code, the link form is therefore a plain copy of the PC into a register.

A parameter selects between two variants. The first is purely combinational. The second registers all results and presents them one cycle later, qualified by a valid strobe.

Top module: `branch_resolve`

## Requirements
- R1: The read indices are presented combinationally from the instruction: `rb_idx` is bits 21..17 and `rc_idx` is bits 16..12.
- R2: The opcode sits in bits 31..27. Opcode 8 is a conditional jump that writes no link, and opcode 9 is a conditional jump that writes a link.
- R3: The test code is instruction bits 2..0, and each value is judged on `rc_val` as follows: 000 never jumps; 001 always jumps; 010 jumps when `rc_val` is zero; 011 jumps when `rc_val` is nonzero; 100 jumps when bit 31 of `rc_val` is 0; 101 jumps when bit 31 of `rc_val` is 1.
- R4: When the jump is taken, `next_pc` equals `rb_val`. Otherwise `next_pc` equals `pc_inc`.
- R5: For opcode 9 with a valid input, `link_we` is 1 whatever the test outcome. In that case `link_idx` is instruction bits 26..22 and `link_data` is `pc_inc`.
- R6: Test codes 110 and 111 never jump.
- R7: For every opcode other than 8 and 9, `link_we` is 0 and `next_pc` equals `pc_inc`.
- R8: With `REGISTERED`=1, the results of a cycle's inputs appear on the outputs after the next rising clock edge, with `out_valid` equal to the previous cycle's `in_valid`. While reset is held, `out_valid` and `link_we` are 0.
- R9: When `in_valid` is 0, `link_we` is 0 and `out_valid` is 0, at the same cycle in the combinational variant and one cycle later in the registered one.
- R10: Instruction bits 11..3 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used by the registered variant) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| pc_inc | input | 32 | PC already advanced past this instruction |
| rb_idx | output | 5 | Read index of the target register |
| rc_idx | output | 5 | Read index of the tested register |
| rb_val | input | 32 | Contents of the target register |
| rc_val | input | 32 | Contents of the tested register |
| out_valid | output | 1 | Results are valid |
| next_pc | output | 32 | PC for the next fetch |
| link_we | output | 1 | Write the link value to the register file |
| link_idx | output | 5 | Register index for the link write |
| link_data | output | 32 | Value written to the link register |

## Verification
The hardest case to reach from the ports is a link write whose jump is not taken. In that case `link_we` is high while `next_pc` stays at `pc_inc`, and an implementation that gates the link with the outcome looks correct on every taken case. The stimulus sweeps every opcode against every test code. It drives the tested register with zero, one, the largest positive value and the sign bit alone, so each code meets operands that make it fail as well as pass. It also fills instruction bits 11..3 with varying junk and drops `in_valid` at intervals, so the ignored bits and the valid gating are both exercised within the same sweep.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN       = 32,
  parameter int RIDX       = 5,
  parameter int OP_JUMP    = 8,
  parameter int OP_JLINK   = 9,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc_inc,
  output logic [RIDX-1:0] rb_idx,
  output logic [RIDX-1:0] rc_idx,
  input  logic [XLEN-1:0] rb_val,
  input  logic [XLEN-1:0] rc_val,
  output logic            out_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [RIDX-1:0] link_idx,
  output logic [XLEN-1:0] link_data
);

  localparam int OPW = 5;
  localparam int TSW = 3;

  logic [OPW-1:0] opcode;
  logic [TSW-1:0] test;
  logic           is_jump, is_link, pass, taken;
  logic [XLEN-1:0] pc_c;
  logic            we_c;

  assign opcode  = instr[31:27];
  assign test    = instr[2:0];
  assign rb_idx  = instr[21:17];
  assign rc_idx  = instr[16:12];
  assign is_link = (opcode == OPW'(OP_JLINK));
  assign is_jump = is_link || (opcode == OPW'(OP_JUMP));

  always_comb begin
    case (test)
      3'b001:  pass = 1'b1;
      3'b010:  pass = (rc_val == '0);
      3'b011:  pass = (rc_val != '0);
      3'b100:  pass = ~rc_val[XLEN-1];
      3'b101:  pass = rc_val[XLEN-1];
      default: pass = 1'b0;
    endcase
  end

  assign taken = is_jump && pass;
  assign pc_c  = taken ? rb_val : pc_inc;
  assign we_c  = in_valid && is_link;

  generate
    if (REGISTERED) begin : g_reg
      logic            v_q, we_q;
      logic [XLEN-1:0] pc_q, ld_q;
      logic [RIDX-1:0] li_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q  <= 1'b0;
          we_q <= 1'b0;
          pc_q <= '0;
          ld_q <= '0;
          li_q <= '0;
        end else begin
          v_q  <= in_valid;
          we_q <= we_c;
          pc_q <= pc_c;
          ld_q <= pc_inc;
          li_q <= instr[26:22];
        end
      end

      assign out_valid = v_q;
      assign link_we   = we_q;
      assign next_pc   = pc_q;
      assign link_data = ld_q;
      assign link_idx  = li_q;

      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r9_no_valid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !link_we));
      a_r5_link_carries_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] == OPW'(OP_JLINK)) |=> (link_we && link_data == $past(pc_inc)));
      a_r7_other_ops_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] != OPW'(OP_JUMP) && instr[31:27] != OPW'(OP_JLINK))
        |=> (!link_we && next_pc == $past(pc_inc)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign link_we   = we_c;
      assign next_pc   = pc_c;
      assign link_data = pc_inc;
      assign link_idx  = instr[26:22];

      a_r5_link_only_op9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (in_valid && instr[31:27] == OPW'(OP_JLINK)));
      a_r6_reserved_codes_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[2:1] == 2'b11) |-> (next_pc == pc_inc));
      a_r7_other_ops_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:27] != OPW'(OP_JUMP) && instr[31:27] != OPW'(OP_JLINK)) |-> (next_pc == pc_inc));
      a_r4_target_or_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc == rb_val) || (next_pc == pc_inc));
    end
  endgenerate

endmodule

// File: tb/sim_branch_resolve.sv
module sim_branch_resolve;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0, pc_inc = '0, rb_val = '0, rc_val = '0;

  logic [4:0]  rb_idx0, rc_idx0, li0, rb_idx1, rc_idx1, li1;
  logic        ov0, we0, ov1, we1;
  logic [31:0] np0, ld0, np1, ld1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_resolve #(.REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc_inc(pc_inc),
    .rb_idx(rb_idx0), .rc_idx(rc_idx0), .rb_val(rb_val), .rc_val(rc_val),
    .out_valid(ov0), .next_pc(np0), .link_we(we0), .link_idx(li0), .link_data(ld0));

  branch_resolve #(.REGISTERED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc_inc(pc_inc),
    .rb_idx(rb_idx1), .rc_idx(rc_idx1), .rb_val(rb_val), .rc_val(rc_val),
    .out_valid(ov1), .next_pc(np1), .link_we(we1), .link_idx(li1), .link_data(ld1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit test_pass(input logic [2:0] c, input logic [31:0] v);
    case (c)
      3'd1: return 1'b1;
      3'd2: return v == 0;
      3'd3: return v != 0;
      3'd4: return v[31] == 1'b0;
      3'd5: return v[31] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic        e_v, e_we;
  logic [31:0] e_pc, e_ld;
  logic [4:0]  e_li;
  bit          have_prev = 0;

  task automatic check_reg();
    chk("R8 out_valid", {31'b0, ov0}, {31'b0, e_v});
    chk("R9 R5 link_we registered", {31'b0, we0}, {31'b0, e_we});
    if (e_v) chk("R8 R4 next_pc registered", np0, e_pc);
    if (e_we) begin
      chk("R5 link_data registered", ld0, e_ld);
      chk("R5 link_idx registered", {27'b0, li0}, {27'b0, e_li});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {31'b0, ov0}, 32'd0);
    chk("R8 reset link_we", {31'b0, we0}, 32'd0);
    rst_n = 1'b1;
    for (int op = 0; op < 32; op++) begin
      for (int c = 0; c < 8; c++) begin
        for (int p = 0; p < 4; p++) begin
          int idx;
          logic [31:0] rcv;
          logic [4:0] ra, rb, rc;
          logic [8:0] junk;
          bit v, tk;
          idx = op * 32 + c * 4 + p;
          case (p)
            0: rcv = 32'h0000_0000;
            1: rcv = 32'h0000_0001;
            2: rcv = 32'h7fff_ffff;
            default: rcv = 32'h8000_0000;
          endcase
          ra = 5'((idx * 7) & 31);
          rb = 5'((idx * 11 + 3) & 31);
          rc = 5'((idx * 13 + 5) & 31);
          junk = 9'((idx * 37) ^ 9'h155);
          v = (idx % 7) != 3;
          @(negedge clk);
          if (have_prev) check_reg();
          in_valid = v;
          instr = {5'(op), ra, rb, rc, junk, 3'(c)};
          pc_inc = 32'h0001_0004 + 32'(idx) * 4;
          rb_val = 32'hC000_0000 ^ (32'(idx) << 4);
          rc_val = rcv;
          tk = (op == 8 || op == 9) && test_pass(3'(c), rcv);
          e_v = v;
          e_we = v && (op == 9);
          e_pc = tk ? rb_val : pc_inc;
          e_ld = pc_inc;
          e_li = ra;
          have_prev = 1;
          #2;
          chk("R1 rb_idx", {27'b0, rb_idx1}, {27'b0, rb});
          chk("R1 rc_idx", {27'b0, rc_idx1}, {27'b0, rc});
          chk("R3 R4 R6 R7 R10 next_pc", np1, e_pc);
          chk("R2 R5 R7 R9 link_we", {31'b0, we1}, {31'b0, e_we});
          chk("R9 out_valid comb", {31'b0, ov1}, {31'b0, e_v});
          if (e_we) begin
            chk("R5 link_data", ld1, e_ld);
            chk("R5 link_idx", {27'b0, li1}, {27'b0, e_li});
          end
        end
      end
    end
    @(negedge clk);
    check_reg();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle out_valid", {31'b0, ov0}, 32'd0);
    chk("R9 idle link_we", {31'b0, we0}, 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule